// File: doc/BRIEF.md
# Privileged Exception Entry Sequencer

This block decides where the program counter goes when the machine enters or leaves privileged mode. Whenever a fault or trap is raised, it picks the winning cause and forms the entry vector. The vector is the privileged base register plus a per-cause offset, and every offset is odd, so bit 0 of the new PC marks privileged mode. The block also works out the restart address that must be written to the external exception-address register, and it tells the register file whether to switch into the shadow bank.

When privileged code executes its return instruction, the block redirects to the saved exception address and signals when the shadow bank must be released. A return issued outside privileged mode is turned into an unimplemented-opcode entry.

The sequencer has two states. BOOT is entered on reset; in it the block issues the reset vector and takes the transition BOOT->RUN on the next clock. RUN is the steady state; its only transition is RUN->RUN, and in RUN the block serves exception requests and returns. All outputs are registered and appear one clock after the inputs that cause them. Each output is a single-cycle pulse.

Top module: `exc_entry_seq`

## Requirements
- R1: In the first clock after reset is released (state BOOT), the block redirects to base+0x0001 with next PC base+0x0005 and raises shadow_enter. It does not write the exception address, and it ignores exc_req and ret_req in that cycle.
- R2: Requests use the exc_req bit positions 0 reset, 1 machine check, 2 arithmetic, 3 integer overflow, 4 interrupt, 5 native data-TLB miss, 6 privileged data-TLB miss, 7 alignment, 8 data-TLB fault, 9 data access violation, 10 instruction-TLB miss, 11 instruction-TLB fault, 12 instruction access violation, 13 unimplemented opcode, 14 floating-point disabled, 15 privileged call. The corresponding offsets are 0x0001, 0x0401, 0x0501, 0x0501, 0x0101, 0x0201, 0x0281, 0x0301, 0x0381, 0x0381, 0x0181, 0x0181, 0x0081, 0x0481, 0x0581, 0x2001. redir_pc is base plus the offset, and redir_npc is redir_pc+4.
- R3: When several exc_req bits are set, the lowest-numbered bit wins. So reset beats machine check, and machine check beats every other cause.
- R4: The restart address written is cur_pc+4 for arithmetic, integer overflow and privileged call, and cur_pc for every other cause.
- R5: An interrupt taken while cur_pc[0]=1 does not write the exception address. Every other exception entry pulses exc_addr_we.
- R6: shadow_enter pulses on exception entry only when cur_pc[0]=0. shadow_enter and shadow_leave are never high together.
- R7: A return request with cur_pc[0]=0 is taken as an unimplemented-opcode entry (offset 0x0481). It saves cur_pc and enters the shadow bank.
- R8: A return request with cur_pc[0]=1 redirects to saved_addr, with next PC saved_addr+4, and does not write the exception address. It pulses shadow_leave only when saved_addr[0]=0.
- R9: When an exception request and a return request arrive in the same cycle, the exception is taken and the return has no effect.
- R10: In RUN, a cycle with no request and no return produces no redirect, no write and no shadow strobe in the following cycle. While reset is asserted, all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | PC_W | PC of the instruction raising the request; bit 0 set means privileged |
| pal_base | input | PC_W | Privileged base-address register value |
| exc_req | input | 16 | One bit per exception cause, see R2 |
| ret_req | input | 1 | Privileged return instruction issued |
| saved_addr | input | PC_W | Current contents of the exception-address register |
| redir_valid | output | 1 | Redirect pulse |
| redir_pc | output | PC_W | New PC |
| redir_npc | output | PC_W | New next PC |
| exc_addr_we | output | 1 | Write strobe for the exception-address register |
| exc_addr_wdata | output | PC_W | Restart address to write |
| shadow_enter | output | 1 | Switch to the shadow register bank |
| shadow_leave | output | 1 | Switch back from the shadow register bank |

## Verification
The hardest case to reach from the ports is the one where several decisions meet in one cycle. An example is an interrupt that wins priority over a privileged call while the machine is already privileged; the write must then be suppressed even though the losing cause would have written. Another is a return that lands in the same cycle as an exception. The stimulus table drives these combined request vectors directly, with cur_pc bit 0 chosen per entry. Reset is released with a request already held, which shows that BOOT ignores it and that RUN serves it on the next clock.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int NCAUSE = 16;
    localparam int CIDX_W = $clog2(NCAUSE);
    localparam int OFF_W  = 16;

    typedef enum logic [CIDX_W-1:0] {
        C_RESET   = 4'd0,
        C_MCHK    = 4'd1,
        C_ARITH   = 4'd2,
        C_IOVF    = 4'd3,
        C_INTR    = 4'd4,
        C_DMISS_N = 4'd5,
        C_DMISS_P = 4'd6,
        C_ALIGN   = 4'd7,
        C_DFAULT  = 4'd8,
        C_DACV    = 4'd9,
        C_IMISS   = 4'd10,
        C_IFAULT  = 4'd11,
        C_IACV    = 4'd12,
        C_UNIMP   = 4'd13,
        C_FPDIS   = 4'd14,
        C_PCALL   = 4'd15
    } cause_e;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Entry offset per cause; bit 0 always set to mark privileged mode.
    function automatic logic [OFF_W-1:0] cause_offset(cause_e c);
        logic [OFF_W-1:0] o;
        unique case (c)
            C_RESET:             o = 16'h0001;
            C_MCHK:              o = 16'h0401;
            C_ARITH, C_IOVF:     o = 16'h0501;
            C_INTR:              o = 16'h0101;
            C_DMISS_N:           o = 16'h0201;
            C_DMISS_P:           o = 16'h0281;
            C_ALIGN:             o = 16'h0301;
            C_DFAULT, C_DACV:    o = 16'h0381;
            C_IMISS, C_IFAULT:   o = 16'h0181;
            C_IACV:              o = 16'h0081;
            C_UNIMP:             o = 16'h0481;
            C_FPDIS:             o = 16'h0581;
            C_PCALL:             o = 16'h2001;
            default:             o = 16'h0001;
        endcase
        return o;
    endfunction

    // Traps resume after the offending instruction.
    function automatic logic is_trap(cause_e c);
        return (c == C_ARITH) || (c == C_IOVF) || (c == C_PCALL);
    endfunction

endpackage

// File: rtl/exc_entry_prio.sv
module exc_entry_prio #(
    parameter  int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    always_comb begin
        if (any) begin
            // R3
            win_is_set_chk: assert (req[idx]);
            // R3
            no_lower_win_chk: assert ((req & ((N'(1) << idx) - N'(1))) == '0);
        end
    end

endmodule

// File: rtl/exc_entry_vec.sv
module exc_entry_vec
    import exc_entry_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  cause_e          cause,
    input  logic [PC_W-1:0] base,
    input  logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] target,
    output logic [PC_W-1:0] target_next,
    output logic [PC_W-1:0] restart,
    output logic            save
);

    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

    always_comb begin
        target      = base + PC_W'(cause_offset(cause));
        target_next = target + INSN_BYTES;
        restart     = is_trap(cause) ? (pc + INSN_BYTES) : pc;
        // an interrupt inside privileged code keeps the older restart address
        save        = !((cause == C_INTR) && pc[0]);
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [PC_W-1:0]   pal_base,
    input  logic [NCAUSE-1:0] exc_req,
    input  logic              ret_req,
    input  logic [PC_W-1:0]   saved_addr,
    output logic              redir_valid,
    output logic [PC_W-1:0]   redir_pc,
    output logic [PC_W-1:0]   redir_npc,
    output logic              exc_addr_we,
    output logic [PC_W-1:0]   exc_addr_wdata,
    output logic              shadow_enter,
    output logic              shadow_leave
);

    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);
    localparam logic [NCAUSE-1:0] INTR_ONLY = NCAUSE'(1) << C_INTR;
    localparam logic [NCAUSE-1:0] PCALL_ONLY = NCAUSE'(1) << C_PCALL;

    seq_state_e state_q, state_d;

    logic              req_any;
    logic [CIDX_W-1:0] req_idx;
    logic              bad_ret;
    logic              good_ret;
    logic              take_exc;
    cause_e            cause_sel;
    logic [PC_W-1:0]   vec_pc, vec_npc, vec_restart;
    logic              vec_save;

    logic              valid_d, we_d, enter_d, leave_d;
    logic [PC_W-1:0]   pc_d, npc_d, wdata_d;

    exc_entry_prio #(.N(NCAUSE)) u_prio (
        .req (exc_req),
        .any (req_any),
        .idx (req_idx)
    );

    always_comb begin
        bad_ret  = ret_req && !cur_pc[0];
        good_ret = ret_req && cur_pc[0] && !req_any;
        take_exc = req_any || bad_ret;
        if (state_q == ST_BOOT) cause_sel = C_RESET;
        else if (req_any)       cause_sel = cause_e'(req_idx);
        else                    cause_sel = C_UNIMP;
    end

    exc_entry_vec #(.PC_W(PC_W)) u_vec (
        .cause       (cause_sel),
        .base        (pal_base),
        .pc          (cur_pc),
        .target      (vec_pc),
        .target_next (vec_npc),
        .restart     (vec_restart),
        .save        (vec_save)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    // outputs
    always_comb begin
        valid_d = 1'b0;
        pc_d    = '0;
        npc_d   = '0;
        we_d    = 1'b0;
        wdata_d = '0;
        enter_d = 1'b0;
        leave_d = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                valid_d = 1'b1;
                pc_d    = vec_pc;
                npc_d   = vec_npc;
                enter_d = 1'b1;
            end
            ST_RUN: begin
                if (take_exc) begin
                    valid_d = 1'b1;
                    pc_d    = vec_pc;
                    npc_d   = vec_npc;
                    we_d    = vec_save;
                    wdata_d = vec_restart;
                    enter_d = !cur_pc[0];
                end else if (good_ret) begin
                    valid_d = 1'b1;
                    pc_d    = saved_addr;
                    npc_d   = saved_addr + INSN_BYTES;
                    leave_d = !saved_addr[0];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redir_valid    <= 1'b0;
            redir_pc       <= '0;
            redir_npc      <= '0;
            exc_addr_we    <= 1'b0;
            exc_addr_wdata <= '0;
            shadow_enter   <= 1'b0;
            shadow_leave   <= 1'b0;
        end else begin
            redir_valid    <= valid_d;
            redir_pc       <= pc_d;
            redir_npc      <= npc_d;
            exc_addr_we    <= we_d;
            exc_addr_wdata <= wdata_d;
            shadow_enter   <= enter_d;
            shadow_leave   <= leave_d;
        end
    end

    // R1
    boot_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |=> (redir_valid && shadow_enter && !exc_addr_we));

    // R6
    enter_leave_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shadow_enter && shadow_leave));

    // R8
    leave_needs_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_leave |-> (redir_valid && !exc_addr_we));

    // R5
    intr_priv_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && exc_req == INTR_ONLY && cur_pc[0]) |=> !exc_addr_we);

    // R4
    pcall_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && exc_req == PCALL_ONLY)
            |=> (exc_addr_we && exc_addr_wdata == $past(cur_pc) + INSN_BYTES));

    // R9
    exc_over_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && (|exc_req) && ret_req) |=> (redir_valid && !shadow_leave));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && exc_req == '0 && !ret_req)
            |=> !(redir_valid || exc_addr_we || shadow_enter || shadow_leave));

endmodule

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;

    localparam int PC_W = 64;
    localparam logic [63:0] BASE = 64'h0000_00A0_0000_0000;

    typedef struct packed {
        logic [15:0] req;
        logic        ret;
        logic [31:0] pc;
        logic [31:0] sav;
        logic        e_valid;
        logic        e_sav;
        logic [15:0] e_off;
        logic        e_we;
        logic        e_skip;
        logic        e_en;
        logic        e_lv;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TBL [NV] = '{
        // R4 arithmetic and integer overflow skip, R2 vectors
        '{16'h0004, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0501, 1'b1, 1'b1, 1'b1, 1'b0, 8'd4},
        '{16'h0008, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0501, 1'b1, 1'b1, 1'b1, 1'b0, 8'd4},
        '{16'h0010, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0101, 1'b1, 1'b0, 1'b1, 1'b0, 8'd2},
        // R5 interrupt while privileged
        '{16'h0010, 1'b0, 32'h2001, 32'h0, 1'b1, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},
        '{16'h0020, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0201, 1'b1, 1'b0, 1'b1, 1'b0, 8'd2},
        // R6 already privileged: no enter
        '{16'h0040, 1'b0, 32'h2001, 32'h0, 1'b1, 1'b0, 16'h0281, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6},
        '{16'h0080, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0301, 1'b1, 1'b0, 1'b1, 1'b0, 8'd2},
        '{16'h0100, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0381, 1'b1, 1'b0, 1'b1, 1'b0, 8'd2},
        '{16'h0200, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0381, 1'b1, 1'b0, 1'b1, 1'b0, 8'd2},
        '{16'h0400, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0181, 1'b1, 1'b0, 1'b1, 1'b0, 8'd2},
        '{16'h0800, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0181, 1'b1, 1'b0, 1'b1, 1'b0, 8'd2},
        '{16'h1000, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0081, 1'b1, 1'b0, 1'b1, 1'b0, 8'd2},
        '{16'h2000, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0481, 1'b1, 1'b0, 1'b1, 1'b0, 8'd2},
        '{16'h4000, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0581, 1'b1, 1'b0, 1'b1, 1'b0, 8'd2},
        '{16'h8000, 1'b0, 32'h2001, 32'h0, 1'b1, 1'b0, 16'h2001, 1'b1, 1'b1, 1'b0, 1'b0, 8'd4},
        '{16'h0002, 1'b0, 32'h2001, 32'h0, 1'b1, 1'b0, 16'h0401, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2},
        // R3 priority
        '{16'hFFFF, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b0, 8'd3},
        '{16'hFFFE, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0401, 1'b1, 1'b0, 1'b1, 1'b0, 8'd3},
        '{16'h8004, 1'b0, 32'h1000, 32'h0, 1'b1, 1'b0, 16'h0501, 1'b1, 1'b1, 1'b1, 1'b0, 8'd3},
        '{16'h8010, 1'b0, 32'h2001, 32'h0, 1'b1, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3},
        // R7 return outside privileged mode
        '{16'h0000, 1'b1, 32'h1000, 32'h3000, 1'b1, 1'b0, 16'h0481, 1'b1, 1'b0, 1'b1, 1'b0, 8'd7},
        // R8 valid returns
        '{16'h0000, 1'b1, 32'h2001, 32'h3000, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'd8},
        '{16'h0000, 1'b1, 32'h2001, 32'h3001, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8},
        // R9 exception beats return
        '{16'h8000, 1'b1, 32'h1000, 32'h3000, 1'b1, 1'b0, 16'h2001, 1'b1, 1'b1, 1'b1, 1'b0, 8'd9},
        // R10 idle
        '{16'h0000, 1'b0, 32'h1000, 32'h3000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd10}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] cur_pc = '0;
    logic [PC_W-1:0] pal_base = BASE;
    logic [15:0]     exc_req = '0;
    logic            ret_req = 1'b0;
    logic [PC_W-1:0] saved_addr = '0;
    logic            redir_valid, exc_addr_we, shadow_enter, shadow_leave;
    logic [PC_W-1:0] redir_pc, redir_npc, exc_addr_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    exc_entry_seq #(.PC_W(PC_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cur_pc         (cur_pc),
        .pal_base       (pal_base),
        .exc_req        (exc_req),
        .ret_req        (ret_req),
        .saved_addr     (saved_addr),
        .redir_valid    (redir_valid),
        .redir_pc       (redir_pc),
        .redir_npc      (redir_npc),
        .exc_addr_we    (exc_addr_we),
        .exc_addr_wdata (exc_addr_wdata),
        .shadow_enter   (shadow_enter),
        .shadow_leave   (shadow_leave)
    );

    task automatic chk(input string rq, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, got, exp);
        end
    endtask

    task automatic chk_idle(input string rq);
        chk(rq, "redir_valid", 64'(redir_valid), 64'd0);
        chk(rq, "exc_addr_we", 64'(exc_addr_we), 64'd0);
        chk(rq, "shadow_enter", 64'(shadow_enter), 64'd0);
        chk(rq, "shadow_leave", 64'(shadow_leave), 64'd0);
    endtask

    task automatic chk_boot(input string rq);
        chk(rq, "boot valid", 64'(redir_valid), 64'd1);
        chk(rq, "boot pc", redir_pc, BASE + 64'h1);
        chk(rq, "boot npc", redir_npc, BASE + 64'h5);
        chk(rq, "boot enter", 64'(shadow_enter), 64'd1);
        chk(rq, "boot we", 64'(exc_addr_we), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 strobes low during reset
        chk_idle("R10");

        // R1: release reset with a request already held; BOOT ignores it
        @(negedge clk);
        exc_req = 16'h8000;
        cur_pc  = 64'h1000;
        rst_n   = 1'b1;
        @(posedge clk);
        #1;
        chk_boot("R1");
        @(posedge clk);
        #1;
        chk("R1", "held pcall pc", redir_pc, BASE + 64'h2001);
        chk("R4", "held pcall wdata", exc_addr_wdata, 64'h1004);

        // table walk
        for (int k = 0; k < NV; k++) begin
            logic [63:0] epc;
            string tag;
            @(negedge clk);
            exc_req    = TBL[k].req;
            ret_req    = TBL[k].ret;
            cur_pc     = 64'(TBL[k].pc);
            saved_addr = 64'(TBL[k].sav);
            @(posedge clk);
            #1;
            tag = $sformatf("R%0d", TBL[k].rq);
            epc = TBL[k].e_sav ? 64'(TBL[k].sav) : BASE + 64'(TBL[k].e_off);
            chk(tag, $sformatf("v%0d valid", k), 64'(redir_valid), 64'(TBL[k].e_valid));
            if (TBL[k].e_valid) begin
                chk(tag, $sformatf("v%0d pc", k), redir_pc, epc);
                chk(tag, $sformatf("v%0d npc", k), redir_npc, epc + 64'd4);
            end
            chk(tag, $sformatf("v%0d we", k), 64'(exc_addr_we), 64'(TBL[k].e_we));
            if (TBL[k].e_we)
                chk(tag, $sformatf("v%0d wdata", k), exc_addr_wdata,
                    64'(TBL[k].pc) + (TBL[k].e_skip ? 64'd4 : 64'd0));
            chk(tag, $sformatf("v%0d enter", k), 64'(shadow_enter), 64'(TBL[k].e_en));
            chk(tag, $sformatf("v%0d leave", k), 64'(shadow_leave), 64'(TBL[k].e_lv));
        end

        // R10 pulses last one cycle: a return followed by idle
        @(negedge clk);
        exc_req = '0; ret_req = 1'b1; cur_pc = 64'h2001; saved_addr = 64'h4000;
        @(posedge clk);
        #1;
        chk("R8", "leave pulse", 64'(shadow_leave), 64'd1);
        @(negedge clk);
        ret_req = 1'b0;
        @(posedge clk);
        #1;
        chk_idle("R10");

        // reset in mid-run clears strobes at once, then BOOT again
        @(negedge clk);
        exc_req = 16'h0004; cur_pc = 64'h1000;
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        chk_idle("R10");
        @(negedge clk);
        exc_req = '0;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_boot("R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule